// File: doc/BRIEF.md
# Masked Packed Integer Narrowing Unit

This unit accepts a packed vector of up to eight 64-bit integer lanes and reduces every lane to 32 bits. A mode input picks one of three reductions: plain truncation, clamping of a signed value into the signed 32-bit range, or clamping of an unsigned value into the unsigned 32-bit range. The narrowed lanes are packed upward from the least significant 32-bit slot, so the result occupies half the width of the active source.

A per-lane mask decides which lanes are written. For a register destination, an unselected lane is either cleared (zeroing) or filled from a caller-supplied previous value (merging), and every bit above the active result is cleared up to the full 512-bit width. For a store destination, the unit instead drives one byte enable per result byte, leaving unselected lanes untouched in memory. A reserved 4-bit field that is not all ones raises a fault that suppresses every write enable. Inputs are captured on a valid strobe and all outputs appear one clock later with a matching valid.

Top module: `masked_narrow`

## Requirements
- R1: With mode 2'b00 (and the unused code 2'b11), each written lane holds bits [31:0] of its 64-bit source lane.
- R2: With mode 2'b01, a source lane read as signed gives 32'h7FFFFFFF when above 2^31-1, 32'h80000000 when below -2^31, and its low 32 bits otherwise.
- R3: With mode 2'b10, a source lane read as unsigned gives 32'hFFFFFFFF when above 2^32-1 and its low 32 bits otherwise.
- R4: lanes_sel 2'b00 selects 2 lanes, 2'b01 selects 4 lanes, 2'b10 or 2'b11 selects 8 lanes; result bits [32j+31:32j] come from src bits [64j+63:64j].
- R5: When mask_en is 0, every lane below the active count is written regardless of mask.
- R6: For a register destination (store_dst 0) with mask_en 1 and zero_mode 1, an active-count lane whose mask bit is 0 reads as zero.
- R7: For a register destination with mask_en 1 and zero_mode 0, an active-count lane whose mask bit is 0 holds the matching 32-bit lane of prev.
- R8: For a register destination, all result bits at or above 32 times the active lane count, up to bit 511, are zero.
- R9: For a store destination (store_dst 1), reg_we is 0 and byte_en bits [4j+3:4j] are all ones exactly when lane j is below the active count and selected by the mask (or mask_en is 0); zero_mode has no effect on byte_en.
- R10: When rsvd differs from 4'b1111, fault is 1 and both reg_we and all byte_en bits are 0.
- R11: Outputs, out_valid and fault update on the clock edge after in_valid is sampled high; out_valid is 0 after a cycle with in_valid low, and after reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operands valid this cycle |
| src | input | 512 | Packed 64-bit source lanes |
| prev | input | 256 | Previous destination contents used for merging |
| mode | input | 2 | Narrowing mode: truncate, signed clamp, unsigned clamp |
| lanes_sel | input | 2 | Active vector length selector |
| mask_en | input | 1 | Write mask in use |
| mask | input | 8 | Per-lane write mask |
| zero_mode | input | 1 | Zeroing (1) or merging (0) for register destinations |
| store_dst | input | 1 | Destination is memory (1) or a register (0) |
| rsvd | input | 4 | Reserved field, must be 4'b1111 |
| out_valid | output | 1 | Outputs valid |
| result | output | 512 | Packed narrowed result |
| reg_we | output | 1 | Register write enable |
| byte_en | output | 32 | Per-byte store enables |
| fault | output | 1 | Illegal encoding fault |

## Verification
The assertions assume in_valid, rsvd, lanes_sel and store_dst are driven with known values from reset onward, since the fault, count and enable checks compare outputs against the inputs sampled one cycle earlier. The bench changes inputs only on the falling clock edge and holds every control input at a defined value in all cycles, including idle ones, so each sampled value is unambiguous.

// File: rtl/masked_narrow.sv
module masked_narrow #(
  parameter int LANES = 8,
  parameter int SRC_W = 64,
  parameter int DST_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [LANES*SRC_W-1:0]   src,
  input  logic [LANES*DST_W-1:0]   prev,
  input  logic [1:0]               mode,
  input  logic [1:0]               lanes_sel,
  input  logic                     mask_en,
  input  logic [LANES-1:0]         mask,
  input  logic                     zero_mode,
  input  logic                     store_dst,
  input  logic [3:0]               rsvd,
  output logic                     out_valid,
  output logic [LANES*SRC_W-1:0]   result,
  output logic                     reg_we,
  output logic [LANES*DST_W/8-1:0] byte_en,
  output logic                     fault
);
  localparam int IN_W  = LANES * SRC_W;
  localparam int HALF  = LANES * DST_W;
  localparam int BE_W  = HALF / 8;
  localparam int BPL   = DST_W / 8;
  localparam int HI_W  = SRC_W - DST_W;

  logic [HALF-1:0]  conv;
  logic [HALF-1:0]  nxt_res;
  logic [BE_W-1:0]  nxt_be;
  logic [LANES-1:0] in_cnt;
  logic             bad;

  assign bad = (rsvd != 4'b1111);

  always_comb begin
    for (int j = 0; j < LANES; j++)
      in_cnt[j] = (lanes_sel == 2'b00) ? (j < LANES/4) :
                  (lanes_sel == 2'b01) ? (j < LANES/2) : 1'b1;
  end

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      logic [SRC_W-1:0] q;
      logic             fits_s, fits_u;
      assign q      = src[g*SRC_W +: SRC_W];
      assign fits_s = (q[SRC_W-1:DST_W-1] == '0) || (q[SRC_W-1:DST_W-1] == '1);
      assign fits_u = (q[SRC_W-1:DST_W] == {HI_W{1'b0}});
      always_comb begin
        unique case (mode)
          2'b01:   conv[g*DST_W +: DST_W] = fits_s ? q[DST_W-1:0] :
                     (q[SRC_W-1] ? {1'b1, {(DST_W-1){1'b0}}} : {1'b0, {(DST_W-1){1'b1}}});
          2'b10:   conv[g*DST_W +: DST_W] = fits_u ? q[DST_W-1:0] : {DST_W{1'b1}};
          default: conv[g*DST_W +: DST_W] = q[DST_W-1:0];
        endcase
      end
    end
  endgenerate

  always_comb begin
    for (int j = 0; j < LANES; j++) begin
      logic sel;
      sel = in_cnt[j] && (!mask_en || mask[j]);
      if (!in_cnt[j])
        nxt_res[j*DST_W +: DST_W] = '0;
      else if (sel || store_dst)
        nxt_res[j*DST_W +: DST_W] = conv[j*DST_W +: DST_W];
      else if (zero_mode)
        nxt_res[j*DST_W +: DST_W] = '0;
      else
        nxt_res[j*DST_W +: DST_W] = prev[j*DST_W +: DST_W];
      nxt_be[j*BPL +: BPL] = {BPL{sel && store_dst && !bad}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      reg_we    <= 1'b0;
      byte_en   <= '0;
      fault     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      reg_we    <= in_valid && !store_dst && !bad;
      byte_en   <= in_valid ? nxt_be : '0;
      fault     <= in_valid && bad;
      if (in_valid)
        result <= {{(IN_W-HALF){1'b0}}, nxt_res};
    end
  end
endmodule

// File: rtl/masked_narrow_chk.sv
module masked_narrow_chk #(
  parameter int LANES = 8,
  parameter int BE_W  = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [1:0]      lanes_sel,
  input logic            store_dst,
  input logic [3:0]      rsvd,
  input logic            out_valid,
  input logic            reg_we,
  input logic [BE_W-1:0] byte_en,
  input logic            fault
);
  localparam int BPL = BE_W / LANES;

  // R10
  fault_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!reg_we && byte_en == '0));

  // R10
  fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rsvd != 4'b1111) |=> fault);

  // R11
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R11
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !reg_we && byte_en == '0));

  // R9
  store_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && store_dst) |=> !reg_we);

  // R9
  store_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && lanes_sel == 2'b00) |=> (byte_en[BE_W-1:BE_W/4] == '0));

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_be
      // R9
      lane_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_en[g*BPL +: BPL] == '0) || (byte_en[g*BPL +: BPL] == '1));
    end
  endgenerate
endmodule

bind masked_narrow masked_narrow_chk #(.LANES(LANES), .BE_W(LANES*DST_W/8)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .lanes_sel(lanes_sel),
  .store_dst(store_dst), .rsvd(rsvd), .out_valid(out_valid), .reg_we(reg_we),
  .byte_en(byte_en), .fault(fault)
);

// File: tb/test_masked_narrow.sv
module test_masked_narrow;
  logic         clk = 0;
  logic         rst_n = 0;
  logic         in_valid = 0;
  logic [511:0] src = '0;
  logic [255:0] prev = '0;
  logic [1:0]   mode = 0;
  logic [1:0]   lanes_sel = 0;
  logic         mask_en = 0;
  logic [7:0]   mask = 0;
  logic         zero_mode = 0;
  logic         store_dst = 0;
  logic [3:0]   rsvd = 4'hF;
  logic         out_valid;
  logic [511:0] result;
  logic         reg_we;
  logic [31:0]  byte_en;
  logic         fault;
  int n_chk = 0;
  int n_fail = 0;

  masked_narrow i_masked_narrow (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src(src), .prev(prev),
    .mode(mode), .lanes_sel(lanes_sel), .mask_en(mask_en), .mask(mask),
    .zero_mode(zero_mode), .store_dst(store_dst), .rsvd(rsvd),
    .out_valid(out_valid), .result(result), .reg_we(reg_we),
    .byte_en(byte_en), .fault(fault)
  );

  always #10 clk = ~clk;

  task automatic chk(string req, logic [511:0] act, logic [511:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] narrow(logic [1:0] m, logic [63:0] q);
    longint          s;
    longint unsigned u;
    s = q;
    u = q;
    if (m == 2'b01) begin
      if (s > 64'sd2147483647) return 32'h7FFFFFFF;
      if (s < -64'sd2147483648) return 32'h80000000;
    end else if (m == 2'b10) begin
      if (u > 64'd4294967295) return 32'hFFFFFFFF;
    end
    return q[31:0];
  endfunction

  task automatic issue();
    @(negedge clk);
    in_valid = 1;
    @(posedge clk);
    #1;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic t_reset();
    chk("R11 reset out_valid", {511'b0, out_valid}, '0);
    chk("R11 reset result", result, '0);
    chk("R11 reset enables", {479'b0, fault, reg_we, byte_en}, '0);
  endtask

  task automatic t_trunc();
    logic [511:0] e;
    e = '0;
    mode = 2'b00; lanes_sel = 2'b10; mask_en = 0; mask = 8'h00; store_dst = 0; rsvd = 4'hF;
    for (int j = 0; j < 8; j++) begin
      src[j*64 +: 64] = {32'hA5A50000 + j, 32'h10203040 + 32'h01010101 * j};
      e[j*32 +: 32] = 32'h10203040 + 32'h01010101 * j;
    end
    @(negedge clk); in_valid = 1;
    @(posedge clk); #1;
    chk("R1 R4 R5 truncate 8 lanes", result, e);
    chk("R11 out_valid after one edge", {511'b0, out_valid}, 512'd1);
    chk("R5 reg_we", {511'b0, reg_we}, 512'd1);
    @(negedge clk); in_valid = 0;
    @(posedge clk); #1;
    chk("R11 idle out_valid low", {511'b0, out_valid}, '0);
    chk("R11 idle holds result", result, e);
  endtask

  task automatic t_sat(logic [1:0] m, string req);
    logic [63:0] v [8];
    logic [511:0] e;
    v = '{64'h000000007FFFFFFF, 64'h0000000080000000, 64'hFFFFFFFF80000000,
          64'hFFFFFFFF7FFFFFFF, 64'hFFFFFFFFFFFFFFFF, 64'h8000000000000000,
          64'h0000000100000000, 64'h0000000000000005};
    e = '0;
    for (int j = 0; j < 8; j++) begin
      src[j*64 +: 64] = v[j];
      e[j*32 +: 32] = narrow(m, v[j]);
    end
    mode = m; lanes_sel = 2'b11; mask_en = 0; store_dst = 0;
    issue();
    chk(req, result, e);
  endtask

  task automatic t_sat_spot();
    src = '0;
    src[63:0] = 64'h0000000080000000;
    src[127:64] = 64'hFFFFFFFF7FFFFFFF;
    mode = 2'b01; lanes_sel = 2'b00; mask_en = 0; store_dst = 0;
    issue();
    chk("R2 clamp literal", result, {448'b0, 32'h80000000, 32'h7FFFFFFF});
    src[63:0] = 64'h00000001FFFFFFFF;
    src[127:64] = 64'h00000000FFFFFFFF;
    mode = 2'b10;
    issue();
    chk("R3 clamp literal", result, {448'b0, 32'hFFFFFFFF, 32'hFFFFFFFF});
  endtask

  task automatic t_zeroing();
    logic [511:0] e;
    e = '0;
    for (int j = 0; j < 8; j++) src[j*64 +: 64] = 64'h1111111100000000 | (64'h100 * (j + 1));
    prev = {8{32'hDEADBEEF}};
    mode = 2'b00; lanes_sel = 2'b01; mask_en = 1; mask = 8'b1010_0101;
    zero_mode = 1; store_dst = 0;
    e[31:0] = 32'h100; e[95:64] = 32'h300;
    issue();
    chk("R6 R8 R4 zeroing 4 lanes", result, e);
  endtask

  task automatic t_merging();
    logic [511:0] e;
    e = '0;
    prev = {32'h77777777, 32'h66666666, 32'h55555555, 32'h44444444,
            32'h33333333, 32'h22222222, 32'h11111111, 32'h0C0C0C0C};
    src[63:0] = 64'hFFFF0000CAFE0001;
    mode = 2'b00; lanes_sel = 2'b00; mask_en = 1; mask = 8'b1111_1110;
    zero_mode = 0; store_dst = 0;
    e[31:0] = 32'h0C0C0C0C; e[63:32] = narrow(2'b00, src[127:64]);
    issue();
    chk("R7 R8 merging 2 lanes", result, e);
    chk("R7 reg_we", {511'b0, reg_we}, 512'd1);
  endtask

  task automatic t_store();
    mode = 2'b00; lanes_sel = 2'b01; mask_en = 1; mask = 8'b1111_0110;
    zero_mode = 1; store_dst = 1; rsvd = 4'hF;
    issue();
    chk("R9 store byte_en", {480'b0, byte_en}, 512'h00000FF0);
    chk("R9 store no reg_we", {511'b0, reg_we}, '0);
    zero_mode = 0; lanes_sel = 2'b10; mask_en = 0;
    issue();
    chk("R9 R5 store unmasked 8 lanes", {480'b0, byte_en}, 512'hFFFFFFFF);
  endtask

  task automatic t_fault();
    lanes_sel = 2'b10; mask_en = 0; store_dst = 1; rsvd = 4'b0111;
    issue();
    chk("R10 store fault", {479'b0, fault, reg_we, byte_en}, {479'b0, 1'b1, 1'b0, 32'h0});
    store_dst = 0; rsvd = 4'b1110;
    issue();
    chk("R10 register fault", {510'b0, fault, reg_we}, 512'd2);
    rsvd = 4'hF;
    issue();
    chk("R10 legal clears fault", {510'b0, fault, reg_we}, 512'd1);
  endtask

  initial begin
    #(20 * 5000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #5;
    t_reset();
    #40;
    @(negedge clk);
    rst_n = 1;
    t_trunc();
    t_sat(2'b01, "R2 signed clamp");
    t_sat(2'b10, "R3 unsigned clamp");
    t_sat(2'b11, "R1 unused mode truncates");
    t_sat_spot();
    t_zeroing();
    t_merging();
    t_store();
    t_fault();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule